// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter

This block sends one byte from a PS/2 peripheral to the host. It generates the bit clock itself from a half-period prescaler. It drives both bus lines as open-drain outputs: each line has a pull-low enable, and the line level is read back through a synchronizer. The user side loads a byte into a one-entry buffer. The block sends the byte only when it sees both lines idle high. It holds the byte back while the host inhibits the bus or wants to send.

While a frame is on the wire, the block checks the clock line near the end of every released half period. If the host holds the clock low before the clock edge that ends the parity bit, the block drops the frame, releases both lines and keeps the byte. It sends the byte again, unchanged, once the bus is idle. Once the parity clock has ended, the frame counts as delivered, even if the host pulls the clock low during the stop bit. One-cycle pulses report a delivered frame and an aborted frame.

Top module: `ps2_dev_tx`

## Requirements
- R1: After reset, neither line is pulled low, `busy` and `pending` are 0, and no `tx_done` or `tx_abort` pulse appears.
- R2: A `tx_valid` pulse while `busy` is 0 stores `tx_data` and sets `pending`. A `tx_valid` pulse while `busy` is 1 has no effect: the frame in progress carries the earlier byte, and no further frame follows it.
- R3: While the sampled clock line is low, no frame starts. The waiting byte may be replaced, and the last byte stored is the one sent after the clock is released.
- R4: While the clock line is high and the data line is low, no frame starts. The frame starts only after the data line returns high.
- R5: A frame has exactly 11 clock-low pulses. The host reads the data line at each falling clock edge, and the bits arrive in this order: a start bit of 0, data bits LSB first, an odd parity bit (so that the nine bits hold an odd number of ones), then a stop bit of 1. The data line changes only while the clock is released and stays stable for the whole low half plus one cycle after the rising edge.
- R6: Each clock-low half and each released half of the frame lasts exactly HALF_TICKS cycles.
- R7: If the host holds the clock low during the released half of any bit from the start bit through the parity bit, then `tx_abort` pulses, both lines are released, and `pending` stays 1. No frame starts while the clock stays low. After release, the same byte is sent again as a complete frame.
- R8: If the host holds the clock low during the released half of the stop bit, then `tx_done` pulses, `tx_abort` does not, and `pending` is 0. Only 10 clock-low pulses are produced.
- R9: A frame that is not interrupted ends with a one-cycle `tx_done` pulse, and `pending` is 0 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_valid | input | 1 | Store `tx_data` in the retry buffer |
| tx_data | input | DATA_W | Byte to send |
| ps2_clk_in | input | 1 | Level on the clock line |
| ps2_dat_in | input | 1 | Level on the data line |
| ps2_clk_pull | output | 1 | Pull the clock line low |
| ps2_dat_pull | output | 1 | Pull the data line low |
| busy | output | 1 | A frame is on the wire |
| pending | output | 1 | The buffer holds a byte not yet delivered |
| tx_done | output | 1 | One-cycle pulse: frame delivered |
| tx_abort | output | 1 | One-cycle pulse: frame dropped by contention |

## Verification
The hardest case to reach is a host pull-down inside one chosen released half-period. The window is only a few cycles long, and the synchronizer delay reduces it further. The bench counts the falling edges of the block's own clock drive. It waits for the release that starts the target bit and then pulls the host clock low on the next cycle. It repeats this for every bit from the start bit through the stop bit, so it hits both sides of the commit point at the parity clock. After each abort it holds the inhibit for a while, and then it checks the automatic resend.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_HIGH = 2'd1,
      TX_LOW  = 2'd2
   } tx_state_e;

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("ps2_line_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sh_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '1;
         else        sh_q <= line_in;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '1;
         else        sh_q <= {sh_q[STAGES-2:0], line_in};
      end
   end

   assign line_q = sh_q[STAGES-1];

endmodule

// File: rtl/ps2_half_timer.sv
module ps2_half_timer #(
   parameter int HALF_TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expire
);

   localparam int CW = $clog2(HALF_TICKS + 1);

   if (HALF_TICKS < 2) begin : g_bad_ticks
      $error("ps2_half_timer: HALF_TICKS must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign expire = (cnt_q == CW'(HALF_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else              cnt_q <= cnt_q + CW'(1);
   end

   AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(HALF_TICKS)); // R6

endmodule

// File: rtl/ps2_frame_pack.sv
module ps2_frame_pack #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W+2:0] frame
);

   localparam int FRAME_LEN = DATA_W + 3;

   if (DATA_W < 1) begin : g_bad_width
      $error("ps2_frame_pack: DATA_W must be at least 1");
   end

   logic odd_bit;
   assign odd_bit = ~(^data);

   for (genvar i = 0; i < FRAME_LEN; i++) begin : g_bit
      if (i == 0) begin : g_start
         assign frame[i] = 1'b0;
      end else if (i <= DATA_W) begin : g_data
         assign frame[i] = data[i-1];
      end else if (i == DATA_W + 1) begin : g_par
         assign frame[i] = odd_bit;
      end else begin : g_stop
         assign frame[i] = 1'b1;
      end
   end

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
   import ps2_tx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int HALF_TICKS  = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              ps2_clk_in,
   input  logic              ps2_dat_in,
   output logic              ps2_clk_pull,
   output logic              ps2_dat_pull,
   output logic              busy,
   output logic              pending,
   output logic              tx_done,
   output logic              tx_abort
);

   localparam int FRAME_LEN  = DATA_W + 3;
   localparam int IDX_W      = $clog2(FRAME_LEN);
   localparam int PARITY_IDX = DATA_W + 1;
   localparam int STOP_IDX   = DATA_W + 2;

   if (HALF_TICKS < SYNC_STAGES + 2) begin : g_bad_half
      $error("ps2_dev_tx: HALF_TICKS too short to see the line after the synchronizer");
   end

   logic                 clk_s;
   logic                 dat_s;
   logic                 expire;
   logic                 restart;
   tx_state_e            state_q;
   logic [IDX_W-1:0]     idx_q;
   logic [DATA_W-1:0]    buf_q;
   logic [FRAME_LEN-1:0] frame_w;
   logic [FRAME_LEN-1:0] frame_q;
   logic                 pend_q;
   logic                 done_q;
   logic                 abort_q;
   logic                 dat_pull_q;
   logic                 bus_free;

   ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .line_in(ps2_clk_in), .line_q(clk_s));

   ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .line_in(ps2_dat_in), .line_q(dat_s));

   ps2_half_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .expire(expire));

   ps2_frame_pack #(.DATA_W(DATA_W)) u_pack (
      .data(buf_q), .frame(frame_w));

   assign restart  = (state_q == TX_IDLE) || expire;
   assign bus_free = clk_s && dat_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         idx_q   <= '0;
         buf_q   <= '0;
         frame_q <= '1;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         abort_q <= 1'b0;
         case (state_q)
            TX_IDLE: begin
               if (tx_valid) begin
                  buf_q  <= tx_data;
                  pend_q <= 1'b1;
               end else if (pend_q && bus_free) begin
                  frame_q <= frame_w;
                  idx_q   <= '0;
                  state_q <= TX_HIGH;
               end
            end
            TX_HIGH: begin
               if (expire) begin
                  if (!clk_s) begin
                     state_q <= TX_IDLE;
                     if (idx_q == IDX_W'(STOP_IDX)) done_q  <= 1'b1;
                     else                           abort_q <= 1'b1;
                  end else begin
                     state_q <= TX_LOW;
                  end
               end
            end
            TX_LOW: begin
               if (expire) begin
                  if (idx_q == IDX_W'(PARITY_IDX)) pend_q <= 1'b0;
                  if (idx_q == IDX_W'(STOP_IDX)) begin
                     state_q <= TX_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q   <= idx_q + IDX_W'(1);
                     state_q <= TX_HIGH;
                  end
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   // data line follows the bit one cycle late, giving hold after the rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dat_pull_q <= 1'b0;
      else        dat_pull_q <= (state_q != TX_IDLE) && !frame_q[idx_q];
   end

   assign ps2_clk_pull = (state_q == TX_LOW);
   assign ps2_dat_pull = dat_pull_q;
   assign busy         = (state_q != TX_IDLE);
   assign pending      = pend_q;
   assign tx_done      = done_q;
   assign tx_abort     = abort_q;

   AST_IDLE_CLK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ps2_clk_pull); // R7
   AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ps2_clk_pull || $past(ps2_clk_pull)) |-> $stable(ps2_dat_pull)); // R5
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_done && tx_abort)); // R8
   AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |-> pending); // R7
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> !pending); // R9
   AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !bus_free) |=> !busy); // R3

endmodule

// File: tb/tb_ps2_dev_tx.sv
module tb_ps2_dev_tx;

   localparam int CLK_PERIOD = 10;
   localparam int H          = 4;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_valid = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       host_clk_low = 1'b0;
   logic       host_dat_low = 1'b0;
   logic       ps2_clk_pull, ps2_dat_pull, busy, pending, tx_done, tx_abort;
   logic       line_clk, line_dat;

   assign line_clk = ~(ps2_clk_pull | host_clk_low);
   assign line_dat = ~(ps2_dat_pull | host_dat_low);

   ps2_dev_tx #(.DATA_W(8), .HALF_TICKS(H), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
      .ps2_clk_in(line_clk), .ps2_dat_in(line_dat),
      .ps2_clk_pull(ps2_clk_pull), .ps2_dat_pull(ps2_dat_pull),
      .busy(busy), .pending(pending), .tx_done(tx_done), .tx_abort(tx_abort));

   always #(CLK_PERIOD/2) clk = ~clk;

   int tests = 0;
   int fails = 0;
   int nf = 0;
   int done_cnt = 0;
   int abort_cnt = 0;
   int cyc = 0;
   int lo = 0, hi = 0, lo_len = 0, hi_len = 0;
   logic [10:0] cap = '0;
   logic pull_d = 1'b0, busy_d = 1'b0;

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         tests++; fails++;
         $display("FAIL watchdog expired at cycle %0d (act hung, exp finished)", cyc);
         finish_run();
      end
      if (busy && !busy_d) begin nf = 0; hi = 0; lo = 0; end
      if (ps2_clk_pull && !pull_d) begin
         if (nf < 11) cap[nf] = line_dat;
         nf++;
         hi_len = hi; hi = 0;
      end
      if (!ps2_clk_pull && pull_d) begin lo_len = lo; lo = 0; end
      if (busy) begin
         if (ps2_clk_pull) lo++;
         else              hi++;
      end
      if (tx_done)  done_cnt++;
      if (tx_abort) abort_cnt++;
      pull_d = ps2_clk_pull;
      busy_d = busy;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [10:0] exp_frame(input logic [7:0] b);
      return {1'b1, ~(^b), b, 1'b0};
   endfunction

   task automatic send(input logic [7:0] b);
      @(negedge clk); tx_valid = 1'b1; tx_data = b;
      @(negedge clk); tx_valid = 1'b0;
   endtask

   task automatic wait_end();
      int d0 = done_cnt;
      int a0 = abort_cnt;
      int t = 0;
      while (done_cnt == d0 && abort_cnt == a0 && t < 20000) begin
         @(negedge clk); t++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int d0, a0;
      logic [7:0] b;
      bit stayed;
      idle(5);
      rst_n = 1'b1;
      idle(3);
      // R1 reset state
      check(!ps2_clk_pull && !ps2_dat_pull, "R1 lines released", {ps2_clk_pull, ps2_dat_pull}, 0);
      check(!busy && !pending, "R1 idle flags", {busy, pending}, 0);
      check(done_cnt == 0 && abort_cnt == 0, "R1 no pulses", done_cnt + abort_cnt, 0);

      // R5 / R9 sweep over all byte values
      for (int v = 0; v < 256; v++) begin
         d0 = done_cnt;
         send(8'(v));
         wait_end();
         check(done_cnt == d0 + 1, "R9 done pulse", done_cnt - d0, 1);
         check(nf == 11 && cap == exp_frame(8'(v)), "R5 frame bits", {nf[15:0], 5'd0, cap}, {16'd11, 5'd0, exp_frame(8'(v))});
         check(!pending, "R9 pending cleared", pending, 0);
         idle(2);
      end
      // R6 half periods (last measured frame)
      check(lo_len == H, "R6 low half", lo_len, H);
      check(hi_len == H, "R6 high half", hi_len, H);

      // R2 write during frame ignored
      d0 = done_cnt;
      send(8'hA5);
      @(posedge busy);
      idle(3);
      send(8'h3C);
      wait_end();
      check(cap == exp_frame(8'hA5), "R2 busy write ignored", cap, exp_frame(8'hA5));
      stayed = 1'b1;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (busy || pending) stayed = 1'b0; end
      check(stayed && done_cnt == d0 + 1, "R2 no extra frame", done_cnt - d0, 1);

      // R3 inhibit with overwrite
      host_clk_low = 1'b1;
      idle(4);
      send(8'h11);
      send(8'h96);
      stayed = 1'b1;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (busy) stayed = 1'b0; end
      check(stayed && pending, "R3 held while inhibited", {stayed, pending}, 2'b11);
      host_clk_low = 1'b0;
      wait_end();
      check(cap == exp_frame(8'h96), "R3 last byte sent", cap, exp_frame(8'h96));

      // R4 host request-to-send
      host_dat_low = 1'b1;
      idle(4);
      send(8'h7E);
      stayed = 1'b1;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (busy) stayed = 1'b0; end
      check(stayed && pending, "R4 held while data low", {stayed, pending}, 2'b11);
      host_dat_low = 1'b0;
      wait_end();
      check(cap == exp_frame(8'h7E) && !pending, "R4 sent after release", cap, exp_frame(8'h7E));

      // R7 / R8 contention on every bit's released half
      for (int k = 0; k <= 10; k++) begin
         b = 8'hC3 ^ 8'(k * 37);
         d0 = done_cnt; a0 = abort_cnt;
         send(b);
         @(posedge busy);
         if (k == 0) begin
            @(negedge clk);
         end else begin
            idle(2);
            wait (nf == k);
            @(negedge ps2_clk_pull);
            @(negedge clk);
         end
         host_clk_low = 1'b1;
         wait_end();
         if (k < 10) begin
            check(abort_cnt == a0 + 1 && done_cnt == d0, "R7 abort pulse", {abort_cnt - a0, done_cnt - d0}, {32'd1, 32'd0});
            stayed = 1'b1;
            for (int i = 0; i < 30; i++) begin
               @(negedge clk);
               if (busy || ps2_clk_pull || ps2_dat_pull || !pending) stayed = 1'b0;
            end
            check(stayed, "R7 released and kept", {busy, ps2_clk_pull, ps2_dat_pull, pending}, 4'b0001);
            host_clk_low = 1'b0;
            wait_end();
            check(done_cnt == d0 + 1 && cap == exp_frame(b) && nf == 11, "R7 resend", cap, exp_frame(b));
            check(!pending, "R7 pending after resend", pending, 0);
         end else begin
            check(done_cnt == d0 + 1 && abort_cnt == a0, "R8 done not abort", {done_cnt - d0, abort_cnt - a0}, {32'd1, 32'd0});
            check(!pending && nf == 10, "R8 committed", {pending, nf[7:0]}, {1'b0, 8'd10});
            host_clk_low = 1'b0;
            idle(30);
            check(!busy && done_cnt == d0 + 1, "R8 no resend", busy, 0);
         end
         idle(3);
      end

      finish_run();
   end

endmodule